// File: doc/BRIEF.md
# PCIe Root Port Bring-Up Sequencer

This block takes a PCIe root-port controller and its serdes PHYs from cold reset to the point where link training may start. After one start pulse it steps through a fixed sequence. Power is switched on while both the controller's core reset and the downstream endpoint reset are held low. The endpoint reset is released after a programmable hold time, and then the core reset. The sideband clock is started, the PHYs are held in reset and the sideband reset is dropped. Each PHY's register port is then selected, and one configuration word is written to every lane through a request/acknowledge command port.

Once every lane has been programmed, the sideband clock is stopped while the PHY hold is removed, and then started again. The controller is put into root-complex mode, and training is enabled as the last step. A lane write that reports a timeout halts the sequence in an error state with training left off. A separate decoder turns two bits of the controller's debug status word into a registered link-up flag.

The sequence runs once per reset. The FSM states, in order, are IDLE, RST_ASSERT, PWR_ON, PERST_WAIT, PERST_REL, PORST_REL, AUXCLK_ON, HOLD_SET, AUXRST_REL, SEL_SET, SEL_WAIT, LANE_GO, LANE_RUN, AUXCLK_OFF, HOLD_CLR, AUXCLK_ON2, DEVTYPE, LTSSM and DONE, with ERR as a side exit. Transitions:
- IDLE moves on when start is seen.
- PERST_WAIT and SEL_WAIT move on when their timer expires.
- LANE_RUN goes to AUXCLK_OFF when the lane engine finishes, or to ERR when it fails.
- Every other state advances after one cycle.
- DONE and ERR are terminal.

Top module: `pcie_rp_bringup`

## Requirements
- R1: After reset: `porst_n_o`=0, `perst_n_o`=0, `pwr_en_o`=0, `aux_clk_en_o`=0, `aux_rst_o`=1, `hold_phy_rst_o`=0, `phy_sel_o`=0, `dev_type_o`=0, `ltssm_en_o`=0, `cmd_req_o`=0, `done_o`=0, `error_o`=0.
- R2: The first output change after start is `pwr_en_o` rising, while both reset outputs are still 0.
- R3: `perst_n_o` rises no earlier than PERST_HOLD_CYC cycles after `pwr_en_o` rises. `porst_n_o` rises in a later cycle, with `perst_n_o` already 1.
- R4: Next, each in its own later cycle and in this order: `aux_clk_en_o` goes to 1, `hold_phy_rst_o` goes to 1, `aux_rst_o` goes to 0, and all `phy_sel_o` bits go to 1.
- R5: The first lane command starts no earlier than SEL_WAIT_CYC cycles after the selects are set.
- R6: Exactly NUM_PHY×LANES_PER_PHY commands are issued, PHY-major and lane-minor. Each carries `cmd_phy_o`=PHY index, `cmd_addr_o`=0x1008+lane×0x100 and `cmd_data_o`=0xE21 (bits 0,5,9,10,11). A request is only raised while `hold_phy_rst_o`=1 and all selects are 1.
- R7: `cmd_req_o` stays high, with phy, address and data stable, until the cycle `cmd_ack_i`=1 is sampled. It then drops for at least one cycle before the next command.
- R8: After the last acknowledge, each in its own cycle and in this order: `aux_clk_en_o` goes to 0, `hold_phy_rst_o` goes to 0, and `aux_clk_en_o` goes back to 1.
- R9: Next, `dev_type_o` becomes 4. In a later cycle `ltssm_en_o` rises, and `done_o` is high for exactly that one cycle.
- R10: An acknowledge with `cmd_err_i`=1 sets `error_o`. After that, no further command or output step follows, `ltssm_en_o` stays 0 and `done_o` never pulses.
- R11: `start_i` has no effect once a sequence has begun, finished or failed, until the next reset.
- R12: `link_up_o` is 1 one cycle after `dbg_status_i` shows bit 4 set and bit 29 clear. It is 0 for every other combination of those two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for the sequence |
| cmd_ack_i | input | 1 | Lane command acknowledge |
| cmd_err_i | input | 1 | Timeout flag, valid with acknowledge |
| dbg_status_i | input | STATUS_W | Controller debug status word |
| porst_n_o | output | 1 | Core power-on reset, active low |
| perst_n_o | output | 1 | Endpoint reset, active low |
| pwr_en_o | output | 1 | Slot power enable |
| aux_clk_en_o | output | 1 | Sideband clock enable |
| aux_rst_o | output | 1 | Sideband reset, active high |
| hold_phy_rst_o | output | 1 | Holds PHYs and training logic in reset |
| phy_sel_o | output | NUM_PHY | Per-PHY register port select |
| dev_type_o | output | DEV_TYPE_W | Device type value |
| ltssm_en_o | output | 1 | Link training enable |
| cmd_req_o | output | 1 | Lane command request |
| cmd_phy_o | output | PHY_W | Target PHY of command |
| cmd_addr_o | output | ADDR_W | Lane register address |
| cmd_data_o | output | DATA_W | Lane register write value |
| link_up_o | output | 1 | Link usable flag |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Sticky lane write failure |

## Verification
The hardest state to reach is the failure exit part-way through lane programming, with some lanes already written and the PHYs still held. The bench reaches it with an acknowledge responder that returns the timeout flag on one chosen command, here the sixth. It then checks that nothing else moves and that later start pulses are ignored. The timing gaps around the endpoint-reset hold and the select settling wait are measured from output edges. Acknowledge latency is varied per command, so the request-hold rule is tested across waits of zero to two cycles.

// File: rtl/pcie_rp_bringup_pkg.sv
package pcie_rp_bringup_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_RST_ASSERT,
        S_PWR_ON,
        S_PERST_WAIT,
        S_PERST_REL,
        S_PORST_REL,
        S_AUXCLK_ON,
        S_HOLD_SET,
        S_AUXRST_REL,
        S_SEL_SET,
        S_SEL_WAIT,
        S_LANE_GO,
        S_LANE_RUN,
        S_AUXCLK_OFF,
        S_HOLD_CLR,
        S_AUXCLK_ON2,
        S_DEVTYPE,
        S_LTSSM,
        S_DONE,
        S_ERR
    } seq_state_e;

    typedef enum logic [1:0] {
        L_IDLE,
        L_ISSUE,
        L_WAIT
    } lane_state_e;

    typedef struct packed {
        logic porst_n;
        logic perst_n;
        logic pwr_en;
        logic aux_clk_en;
        logic aux_rst;
        logic hold_phy_rst;
        logic ltssm_en;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        porst_n:      1'b0,
        perst_n:      1'b0,
        pwr_en:       1'b0,
        aux_clk_en:   1'b0,
        aux_rst:      1'b1,
        hold_phy_rst: 1'b0,
        ltssm_en:     1'b0
    };

endpackage

// File: rtl/pcie_bringup_timer.sv
module pcie_bringup_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] value_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= value_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/pcie_lane_cfg_master.sv
module pcie_lane_cfg_master
    import pcie_rp_bringup_pkg::*;
#(
    parameter int              NUM_PHY       = 2,
    parameter int              LANES_PER_PHY = 4,
    parameter int              PHY_W         = 1,
    parameter int              ADDR_W        = 16,
    parameter int              DATA_W        = 32,
    parameter logic [ADDR_W-1:0] LANE_BASE   = 16'h1008,
    parameter logic [ADDR_W-1:0] LANE_STRIDE = 16'h0100,
    parameter logic [DATA_W-1:0] LANE_INIT   = 32'h0000_0E21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              ack_i,
    input  logic              err_i,
    output logic              req_o,
    output logic [PHY_W-1:0]  phy_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              done_o,
    output logic              fail_o
);

    localparam int TOTAL = NUM_PHY * LANES_PER_PHY;
    localparam int IDX_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;

    lane_state_e      lst_q, lst_d;
    logic [IDX_W-1:0] idx_q;
    logic             last_cmd;
    int               lane_i;
    int               phy_i;

    assign last_cmd = (idx_q == IDX_W'(TOTAL - 1));

    // Command fields derived from the running index
    always_comb begin
        lane_i = int'(idx_q) % LANES_PER_PHY;
        phy_i  = int'(idx_q) / LANES_PER_PHY;
        phy_o  = PHY_W'(phy_i);
        addr_o = ADDR_W'(int'(LANE_BASE) + lane_i * int'(LANE_STRIDE));
        data_o = LANE_INIT;
    end

    always_comb begin
        lst_d = lst_q;
        unique case (lst_q)
            L_IDLE:  if (go_i) lst_d = L_ISSUE;
            L_ISSUE: lst_d = L_WAIT;
            L_WAIT: begin
                if (ack_i) begin
                    if (err_i || last_cmd) lst_d = L_IDLE;
                    else                   lst_d = L_ISSUE;
                end
            end
            default: lst_d = L_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lst_q <= L_IDLE;
        else        lst_q <= lst_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            req_o  <= 1'b0;
            done_o <= 1'b0;
            fail_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            fail_o <= 1'b0;
            unique case (lst_q)
                L_IDLE:  if (go_i) idx_q <= '0;
                L_ISSUE: req_o <= 1'b1;
                L_WAIT: begin
                    if (ack_i) begin
                        req_o <= 1'b0;
                        if (err_i)         fail_o <= 1'b1;
                        else if (last_cmd) done_o <= 1'b1;
                        else               idx_q  <= idx_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(phy_o)));

    // R7
    req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i) |=> !req_o);

endmodule

// File: rtl/pcie_link_status.sv
module pcie_link_status #(
    parameter int STATUS_W  = 32,
    parameter int UP_BIT    = 4,
    parameter int TRAIN_BIT = 29
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] status_i,
    output logic                link_up_o
);

    logic unused_status;
    assign unused_status = ^status_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) link_up_o <= 1'b0;
        else        link_up_o <= status_i[UP_BIT] & ~status_i[TRAIN_BIT];
    end

    // R12
    link_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(status_i[TRAIN_BIT]) |-> !link_up_o);

endmodule

// File: rtl/pcie_rp_bringup.sv
module pcie_rp_bringup
    import pcie_rp_bringup_pkg::*;
#(
    parameter int NUM_PHY        = 2,
    parameter int LANES_PER_PHY  = 4,
    parameter int ADDR_W         = 16,
    parameter int DATA_W         = 32,
    parameter int STATUS_W       = 32,
    parameter int DEV_TYPE_W     = 4,
    parameter int PERST_HOLD_CYC = 25000,
    parameter int SEL_WAIT_CYC   = 250,
    parameter logic [ADDR_W-1:0]     LANE_BASE   = 16'h1008,
    parameter logic [ADDR_W-1:0]     LANE_STRIDE = 16'h0100,
    parameter logic [DATA_W-1:0]     LANE_INIT   = 32'h0000_0E21,
    parameter logic [DEV_TYPE_W-1:0] DEV_TYPE_RC = 4'd4,
    parameter int UP_BIT         = 4,
    parameter int TRAIN_BIT      = 29,
    localparam int PHY_W = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  cmd_ack_i,
    input  logic                  cmd_err_i,
    input  logic [STATUS_W-1:0]   dbg_status_i,
    output logic                  porst_n_o,
    output logic                  perst_n_o,
    output logic                  pwr_en_o,
    output logic                  aux_clk_en_o,
    output logic                  aux_rst_o,
    output logic                  hold_phy_rst_o,
    output logic [NUM_PHY-1:0]    phy_sel_o,
    output logic [DEV_TYPE_W-1:0] dev_type_o,
    output logic                  ltssm_en_o,
    output logic                  cmd_req_o,
    output logic [PHY_W-1:0]      cmd_phy_o,
    output logic [ADDR_W-1:0]     cmd_addr_o,
    output logic [DATA_W-1:0]     cmd_data_o,
    output logic                  link_up_o,
    output logic                  done_o,
    output logic                  error_o
);

    localparam int MAX_WAIT = (PERST_HOLD_CYC > SEL_WAIT_CYC) ? PERST_HOLD_CYC : SEL_WAIT_CYC;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1) + 1;

    seq_state_e                state_q, state_d;
    ctl_t                      ctl_q;
    logic [NUM_PHY-1:0]        sel_q;
    logic [DEV_TYPE_W-1:0]     dtype_q;
    logic                      done_q;
    logic                      error_q;

    logic                      tmr_load;
    logic [CNT_W-1:0]          tmr_value;
    logic                      tmr_expired;
    logic                      lane_go;
    logic                      lane_done;
    logic                      lane_fail;

    // Wait timer shared by the reset hold and the select settle
    assign tmr_load  = (state_q == S_PWR_ON) || (state_q == S_SEL_SET);
    assign tmr_value = (state_q == S_PWR_ON) ? CNT_W'(PERST_HOLD_CYC) : CNT_W'(SEL_WAIT_CYC);
    assign lane_go   = (state_q == S_LANE_GO);

    pcie_bringup_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .value_i   (tmr_value),
        .expired_o (tmr_expired)
    );

    pcie_lane_cfg_master #(
        .NUM_PHY       (NUM_PHY),
        .LANES_PER_PHY (LANES_PER_PHY),
        .PHY_W         (PHY_W),
        .ADDR_W        (ADDR_W),
        .DATA_W        (DATA_W),
        .LANE_BASE     (LANE_BASE),
        .LANE_STRIDE   (LANE_STRIDE),
        .LANE_INIT     (LANE_INIT)
    ) lanes_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (lane_go),
        .ack_i  (cmd_ack_i),
        .err_i  (cmd_err_i),
        .req_o  (cmd_req_o),
        .phy_o  (cmd_phy_o),
        .addr_o (cmd_addr_o),
        .data_o (cmd_data_o),
        .done_o (lane_done),
        .fail_o (lane_fail)
    );

    pcie_link_status #(
        .STATUS_W  (STATUS_W),
        .UP_BIT    (UP_BIT),
        .TRAIN_BIT (TRAIN_BIT)
    ) link_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_i  (dbg_status_i),
        .link_up_o (link_up_o)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (start_i) state_d = S_RST_ASSERT;
            S_RST_ASSERT: state_d = S_PWR_ON;
            S_PWR_ON:     state_d = S_PERST_WAIT;
            S_PERST_WAIT: if (tmr_expired) state_d = S_PERST_REL;
            S_PERST_REL:  state_d = S_PORST_REL;
            S_PORST_REL:  state_d = S_AUXCLK_ON;
            S_AUXCLK_ON:  state_d = S_HOLD_SET;
            S_HOLD_SET:   state_d = S_AUXRST_REL;
            S_AUXRST_REL: state_d = S_SEL_SET;
            S_SEL_SET:    state_d = S_SEL_WAIT;
            S_SEL_WAIT:   if (tmr_expired) state_d = S_LANE_GO;
            S_LANE_GO:    state_d = S_LANE_RUN;
            S_LANE_RUN: begin
                if (lane_fail)      state_d = S_ERR;
                else if (lane_done) state_d = S_AUXCLK_OFF;
            end
            S_AUXCLK_OFF: state_d = S_HOLD_CLR;
            S_HOLD_CLR:   state_d = S_AUXCLK_ON2;
            S_AUXCLK_ON2: state_d = S_DEVTYPE;
            S_DEVTYPE:    state_d = S_LTSSM;
            S_LTSSM:      state_d = S_DONE;
            S_DONE:       state_d = S_DONE;
            S_ERR:        state_d = S_ERR;
            default:      state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Output register: each action state performs one step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= CTL_RESET;
            sel_q   <= '0;
            dtype_q <= '0;
            done_q  <= 1'b0;
            error_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_RST_ASSERT: begin
                    ctl_q.porst_n <= 1'b0;
                    ctl_q.perst_n <= 1'b0;
                end
                S_PWR_ON:     ctl_q.pwr_en       <= 1'b1;
                S_PERST_REL:  ctl_q.perst_n      <= 1'b1;
                S_PORST_REL:  ctl_q.porst_n      <= 1'b1;
                S_AUXCLK_ON:  ctl_q.aux_clk_en   <= 1'b1;
                S_HOLD_SET:   ctl_q.hold_phy_rst <= 1'b1;
                S_AUXRST_REL: ctl_q.aux_rst      <= 1'b0;
                S_SEL_SET:    sel_q              <= '1;
                S_LANE_RUN:   if (lane_fail) error_q <= 1'b1;
                S_AUXCLK_OFF: ctl_q.aux_clk_en   <= 1'b0;
                S_HOLD_CLR:   ctl_q.hold_phy_rst <= 1'b0;
                S_AUXCLK_ON2: ctl_q.aux_clk_en   <= 1'b1;
                S_DEVTYPE:    dtype_q            <= DEV_TYPE_RC;
                S_LTSSM: begin
                    ctl_q.ltssm_en <= 1'b1;
                    done_q         <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign porst_n_o      = ctl_q.porst_n;
    assign perst_n_o      = ctl_q.perst_n;
    assign pwr_en_o       = ctl_q.pwr_en;
    assign aux_clk_en_o   = ctl_q.aux_clk_en;
    assign aux_rst_o      = ctl_q.aux_rst;
    assign hold_phy_rst_o = ctl_q.hold_phy_rst;
    assign ltssm_en_o     = ctl_q.ltssm_en;
    assign phy_sel_o      = sel_q;
    assign dev_type_o     = dtype_q;
    assign done_o         = done_q;
    assign error_o        = error_q;

    // Cycles since power came on, for the reset-hold check
    logic [CNT_W-1:0] pwr_age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                          pwr_age_q <= '0;
        else if (pwr_en_o && pwr_age_q < CNT_W'(PERST_HOLD_CYC)) pwr_age_q <= pwr_age_q + 1'b1;
    end

    // R2
    pwr_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en_o) |-> (!perst_n_o && !porst_n_o));

    // R3
    perst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perst_n_o) |-> (pwr_age_q >= CNT_W'(PERST_HOLD_CYC)));

    // R3
    porst_after_perst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(porst_n_o) |-> (perst_n_o && !$rose(perst_n_o)));

    // R6
    cmd_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req_o |-> (hold_phy_rst_o && (&phy_sel_o)));

    // R8
    hold_clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_phy_rst_o) |-> !aux_clk_en_o);

    // R9
    ltssm_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ltssm_en_o |-> (!hold_phy_rst_o && dev_type_o == DEV_TYPE_RC));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    err_no_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> (!ltssm_en_o && !cmd_req_o));

endmodule

// File: tb/pcie_rp_bringup_tb_top.sv
module pcie_rp_bringup_tb_top;

    localparam int PERST = 40;
    localparam int SELW  = 8;
    localparam int NCMD  = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, start_i, cmd_ack_i, cmd_err_i;
    logic [31:0] dbg_status_i;
    logic        porst_n_o, perst_n_o, pwr_en_o, aux_clk_en_o, aux_rst_o, hold_phy_rst_o;
    logic [1:0]  phy_sel_o;
    logic [3:0]  dev_type_o;
    logic        ltssm_en_o, cmd_req_o;
    logic [0:0]  cmd_phy_o;
    logic [15:0] cmd_addr_o;
    logic [31:0] cmd_data_o;
    logic        link_up_o, done_o, error_o;

    pcie_rp_bringup #(
        .PERST_HOLD_CYC (PERST),
        .SEL_WAIT_CYC   (SELW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_ack_i(cmd_ack_i),
        .cmd_err_i(cmd_err_i), .dbg_status_i(dbg_status_i),
        .porst_n_o(porst_n_o), .perst_n_o(perst_n_o), .pwr_en_o(pwr_en_o),
        .aux_clk_en_o(aux_clk_en_o), .aux_rst_o(aux_rst_o),
        .hold_phy_rst_o(hold_phy_rst_o), .phy_sel_o(phy_sel_o),
        .dev_type_o(dev_type_o), .ltssm_en_o(ltssm_en_o), .cmd_req_o(cmd_req_o),
        .cmd_phy_o(cmd_phy_o), .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o),
        .link_up_o(link_up_o), .done_o(done_o), .error_o(error_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [12:0] pack(logic porst, logic perst, logic pwr, logic aclk,
                                         logic arst, logic hold, logic [1:0] sel,
                                         logic lt, logic [3:0] dt);
        return {porst, perst, pwr, aclk, arst, hold, sel, lt, dt};
    endfunction

    localparam logic [12:0] VEC_RESET = 13'b0_0_0_0_1_0_00_0_0000;

    // Scoreboard queues
    logic [12:0] exp_ctl[$];
    string       exp_tag[$];
    logic [48:0] exp_cmd[$];

    // Driver: expected output steps in order
    task automatic push_steps(input int n);
        logic porst = 0, perst = 0, pwr = 0, aclk = 0, arst = 1, hold = 0, lt = 0;
        logic [1:0] sel = 0;
        logic [3:0] dt = 0;
        for (int s = 1; s <= n; s++) begin
            string tag;
            case (s)
                1:  begin pwr = 1;   tag = "R2"; end
                2:  begin perst = 1; tag = "R3"; end
                3:  begin porst = 1; tag = "R3"; end
                4:  begin aclk = 1;  tag = "R4"; end
                5:  begin hold = 1;  tag = "R4"; end
                6:  begin arst = 0;  tag = "R4"; end
                7:  begin sel = 2'b11; tag = "R4"; end
                8:  begin aclk = 0;  tag = "R8"; end
                9:  begin hold = 0;  tag = "R8"; end
                10: begin aclk = 1;  tag = "R8"; end
                11: begin dt = 4'd4; tag = "R9"; end
                default: begin lt = 1; tag = "R9"; end
            endcase
            exp_ctl.push_back(pack(porst, perst, pwr, aclk, arst, hold, sel, lt, dt));
            exp_tag.push_back(tag);
        end
    endtask

    task automatic push_cmds(input int n);
        for (int k = 0; k < n; k++) begin
            logic [15:0] a;
            a = 16'h1008 + 16'((k % 4) * 16'h100);
            exp_cmd.push_back({1'(k / 4), a, 32'h0000_0E21});
        end
    endtask

    // Acknowledge responder
    bit err_mode = 0;
    int err_idx = 5;
    int n_ack = 0;
    int wait_ctr = 0;
    initial begin
        cmd_ack_i = 0;
        cmd_err_i = 0;
        forever begin
            @(negedge clk);
            cmd_ack_i = 0;
            cmd_err_i = 0;
            if (rst_n && cmd_req_o) begin
                if (wait_ctr >= n_ack % 3) begin
                    cmd_ack_i = 1;
                    cmd_err_i = err_mode && (n_ack == err_idx);
                    n_ack++;
                    wait_ctr = 0;
                end else begin
                    wait_ctr++;
                end
            end
        end
    end

    // Monitor
    int cyc = 0, t_pwr = 0, t_sel = 0, done_cnt = 0;
    bit first_cmd = 1;
    logic [12:0] prev;
    logic prev_req = 0;
    logic [48:0] prev_fields;
    always @(negedge clk) begin
        logic [12:0] cur;
        logic [48:0] fields;
        cur = pack(porst_n_o, perst_n_o, pwr_en_o, aux_clk_en_o, aux_rst_o,
                   hold_phy_rst_o, phy_sel_o, ltssm_en_o, dev_type_o);
        fields = {cmd_phy_o, cmd_addr_o, cmd_data_o};
        cyc++;
        if (!rst_n) begin
            prev = cur;
            prev_req = 0;
            first_cmd = 1;
        end else begin
            if (cur != prev) begin
                if (exp_ctl.size() == 0) begin
                    check(0, "R11", "unexpected output step", 64'(cur), 64'(prev));
                end else begin
                    logic [12:0] e;
                    string t;
                    e = exp_ctl.pop_front();
                    t = exp_tag.pop_front();
                    check(cur == e, t, "output step", 64'(cur), 64'(e));
                end
                if (!prev[10] && cur[10]) t_pwr = cyc;
                if (!prev[11] && cur[11])
                    check(cyc - t_pwr >= PERST, "R3", "reset hold cycles", 64'(cyc - t_pwr), 64'(PERST));
                if (prev[6:5] != 2'b11 && cur[6:5] == 2'b11) t_sel = cyc;
                if (!prev[4] && cur[4])
                    check(done_o == 1'b1, "R9", "done with training enable", 64'(done_o), 64'(1));
            end
            if (done_o) done_cnt++;
            if (cmd_req_o && !prev_req) begin
                if (first_cmd)
                    check(cyc - t_sel >= SELW, "R5", "select settle cycles", 64'(cyc - t_sel), 64'(SELW));
                first_cmd = 0;
                if (exp_cmd.size() == 0) begin
                    check(0, "R10", "unexpected command", 64'(fields), 64'(0));
                end else begin
                    logic [48:0] ec;
                    ec = exp_cmd.pop_front();
                    check(fields == ec, "R6", "command fields", 64'(fields), 64'(ec));
                end
                check(hold_phy_rst_o && phy_sel_o == 2'b11, "R6", "hold during command",
                      64'({hold_phy_rst_o, phy_sel_o}), 64'(7));
            end
            if (cmd_req_o && prev_req)
                check(fields == prev_fields, "R7", "request fields stable", 64'(fields), 64'(prev_fields));
            prev = cur;
            prev_req = cmd_req_o;
            prev_fields = fields;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start_i = 1;
        @(negedge clk) start_i = 0;
    endtask

    task automatic link_case(input logic [31:0] v, input logic exp);
        @(negedge clk) dbg_status_i = v;
        @(negedge clk);
        check(link_up_o == exp, "R12", "link flag", 64'(link_up_o), 64'(exp));
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
    end

    initial begin
        rst_n = 0;
        start_i = 0;
        dbg_status_i = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check({porst_n_o, perst_n_o, pwr_en_o, aux_clk_en_o, aux_rst_o, hold_phy_rst_o,
               phy_sel_o, ltssm_en_o, dev_type_o} == VEC_RESET, "R1", "control outputs",
              64'({porst_n_o, perst_n_o, pwr_en_o, aux_clk_en_o, aux_rst_o, hold_phy_rst_o,
                   phy_sel_o, ltssm_en_o, dev_type_o}), 64'(VEC_RESET));
        check({cmd_req_o, done_o, error_o, link_up_o} == 4'b0, "R1", "status outputs",
              64'({cmd_req_o, done_o, error_o, link_up_o}), 64'(0));

        // R12 link decode patterns
        link_case(32'h0000_0010, 1'b1);
        link_case(32'h2000_0010, 1'b0);
        link_case(32'h0000_0000, 1'b0);
        link_case(32'hFFFF_FFEF, 1'b0);
        link_case(32'hDFFF_FFFF, 1'b1);

        // Run 1: full sequence
        push_steps(12);
        push_cmds(NCMD);
        pulse_start();
        repeat (15) @(negedge clk);
        pulse_start();  // R11: ignored mid-run
        for (int i = 0; i < 3000 && !ltssm_en_o; i++) @(negedge clk);
        repeat (10) @(negedge clk);
        check(ltssm_en_o == 1'b1, "R9", "training enabled", 64'(ltssm_en_o), 64'(1));
        check(error_o == 1'b0, "R10", "no error on clean run", 64'(error_o), 64'(0));
        pulse_start();  // R11: ignored after completion
        repeat (50) @(negedge clk);
        check(exp_ctl.size() == 0, "R11", "all steps seen once", 64'(exp_ctl.size()), 64'(0));
        check(exp_cmd.size() == 0, "R6", "all commands seen", 64'(exp_cmd.size()), 64'(0));
        check(done_cnt == 1, "R9", "single done pulse", 64'(done_cnt), 64'(1));

        // Run 2: timeout on the sixth command
        rst_n = 0;
        repeat (3) @(negedge clk);
        err_mode = 1;
        n_ack = 0;
        wait_ctr = 0;
        rst_n = 1;
        @(negedge clk);
        push_steps(7);
        push_cmds(6);
        pulse_start();
        for (int i = 0; i < 3000 && !error_o; i++) @(negedge clk);
        repeat (50) @(negedge clk);
        check(error_o == 1'b1, "R10", "error flag", 64'(error_o), 64'(1));
        check(ltssm_en_o == 1'b0, "R10", "training stays off", 64'(ltssm_en_o), 64'(0));
        check(cmd_req_o == 1'b0, "R10", "no request after fail", 64'(cmd_req_o), 64'(0));
        check(exp_cmd.size() == 0, "R10", "commands up to failure", 64'(exp_cmd.size()), 64'(0));
        pulse_start();  // R11: ignored in error state
        repeat (30) @(negedge clk);
        check(exp_ctl.size() == 0, "R10", "steps up to failure", 64'(exp_ctl.size()), 64'(0));
        check(done_cnt == 1, "R10", "no done after failure", 64'(done_cnt), 64'(1));
        check(error_o == 1'b1 && hold_phy_rst_o == 1'b1, "R11", "state held after start",
              64'({error_o, hold_phy_rst_o}), 64'(3));
        summary();
    end

endmodule